// File: doc/BRIEF.md
# Conditional trap comparator

This combinational unit decides whether a conditional-trap instruction fires. It takes two 64-bit operands, a flag that selects 32-bit operation, the 32-bit instruction word and a 5-bit forced-trap type vector.

From the two operands it forms five relations side by side: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. In 32-bit mode only the low half of each operand takes part. That half is sign-extended for the signed relations and zero-extended for the unsigned relations and for equality.

The five relations are packed into a compare vector. This vector is ANDed with a 5-bit condition mask taken from a fixed field of the instruction word. The trap is taken when any masked relation holds, or when the forced-trap type is nonzero. The compare vector is also brought out so that the surrounding pipeline and the bench can see it.

Top module: `trapcmp_unit`

## Requirements
- R1: The condition mask is instruction bits 25 down to 21 (bit 0 is the least significant bit of the word). Mask bit k selects compare vector bit k. Instruction bits outside that field have no effect on either output.
- R2: When `narrow_i` is 1, the signed relations compare the low 32 bits of each operand, sign-extended to 64 bits.
- R3: When `narrow_i` is 1, the unsigned relations compare the low 32 bits of each operand, zero-extended. The upper 32 bits of both operands have no effect on either output.
- R4: When `narrow_i` is 0, both the signed and the unsigned relations use the full 64-bit operands.
- R5: `cmp_o` bit 4 is signed less-than, bit 3 is signed greater-than, bit 2 is equal, bit 1 is unsigned less-than and bit 0 is unsigned greater-than.
- R6: Equality is computed on the zero-extended forms. In 32-bit mode, operands whose low halves match are equal even when their upper halves differ.
- R7: With `force_type_i` zero, `take_o` is 1 exactly when `cmp_o` ANDed with the mask is nonzero.
- R8: Any nonzero `force_type_i` sets `take_o` to 1, whatever the operands and the mask are.
- R9: A zero mask together with a zero `force_type_i` gives `take_o` = 0 for all operands.
- R10: Exactly one of signed less-than, signed greater-than and equal is 1. Exactly one of unsigned less-than, unsigned greater-than and equal is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| narrow_i | input | 1 | 1 selects 32-bit compares on the low halves |
| insn_i | input | 32 | Instruction word; bits 25:21 hold the condition mask |
| force_type_i | input | 5 | Forced-trap type; any nonzero value forces the trap |
| take_o | output | 1 | Trap decision |
| cmp_o | output | 5 | Compare vector {slt, sgt, eq, ult, ugt} |

## Verification
Some directed pairs have a negative operand against a positive one. Their signed and unsigned relations disagree, which separates the two comparator paths and shows the bit order of the compare vector. Other pairs differ only in their upper halves. In 32-bit mode they must compare equal and the same in both signednesses; in 64-bit mode they must not, which exposes any wrong extension. Each mask bit is set alone, with every instruction bit outside the field set to one, to catch a misplaced field. Forced-type values run against a zero mask. A long pseudo-random run then mixes in operands with equal and shared low halves, so that the equality and the strict relations are all reached in both modes.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;
  localparam int CMP_W   = 5;
  localparam int SLT_BIT = 4;
  localparam int SGT_BIT = 3;
  localparam int EQ_BIT  = 2;
  localparam int ULT_BIT = 1;
  localparam int UGT_BIT = 0;

  // packed so that slt lands in bit 4 and ugt in bit 0
  typedef struct packed {
    logic slt;
    logic sgt;
    logic eq;
    logic ult;
    logic ugt;
  } cmp_vec_t;

  function automatic logic [CMP_W-1:0] mask_and(input cmp_vec_t v, input logic [CMP_W-1:0] m);
    return v & m;
  endfunction
endpackage

// File: rtl/trapcmp_operand_prep.sv
module trapcmp_operand_prep #(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            narrow,
  output logic [XLEN-1:0] sa,
  output logic [XLEN-1:0] sb,
  output logic [XLEN-1:0] ua,
  output logic [XLEN-1:0] ub
);
  localparam int UPPER = XLEN - HALF;

  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v,
                                            input logic sgn, input logic nar);
    logic fill;
    fill = sgn & v[HALF-1];
    if (!nar) return v;
    return {{UPPER{fill}}, v[HALF-1:0]};
  endfunction

  logic [XLEN-1:0] src [2];
  logic [XLEN-1:0] sx  [2];
  logic [XLEN-1:0] zx  [2];

  assign src[0] = opa;
  assign src[1] = opb;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    assign sx[g] = widen(src[g], 1'b1, narrow);
    assign zx[g] = widen(src[g], 1'b0, narrow);

    always_comb begin
      // R3
      zext_upper_chk: assert (!narrow || zx[g][XLEN-1:HALF] == '0);
      // R2
      sext_upper_chk: assert (!narrow || sx[g][XLEN-1:HALF] == {UPPER{src[g][HALF-1]}});
      // R4
      wide_pass_chk: assert (narrow || (sx[g] == src[g] && zx[g] == src[g]));
    end
  end

  assign sa = sx[0];
  assign sb = sx[1];
  assign ua = zx[0];
  assign ub = zx[1];
endmodule

// File: rtl/trapcmp_compare.sv
module trapcmp_compare
  import trapcmp_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] sa,
  input  logic [XLEN-1:0] sb,
  input  logic [XLEN-1:0] ua,
  input  logic [XLEN-1:0] ub,
  output cmp_vec_t        cmp
);
  logic s_lt, s_gt, u_lt, u_gt, u_eq;

  assign s_lt = $signed(sa) < $signed(sb);
  assign s_gt = $signed(sa) > $signed(sb);
  assign u_lt = ua < ub;
  assign u_gt = ua > ub;
  assign u_eq = ua == ub;

  assign cmp = '{slt: s_lt, sgt: s_gt, eq: u_eq, ult: u_lt, ugt: u_gt};

  always_comb begin
    // R10
    signed_trio_chk: assert ($countones({s_lt, s_gt, u_eq}) == 1);
    // R10
    unsigned_trio_chk: assert ($countones({u_lt, u_gt, u_eq}) == 1);
  end
endmodule

// File: rtl/trapcmp_decide.sv
module trapcmp_decide
  import trapcmp_pkg::*;
#(
  parameter int INSN_W   = 32,
  parameter int MASK_LSB = 21,
  parameter int TYPE_W   = 5
) (
  input  logic [INSN_W-1:0] insn,
  input  logic [TYPE_W-1:0] force_type,
  input  cmp_vec_t          cmp,
  output logic              take
);
  localparam int MASK_MSB = MASK_LSB + CMP_W - 1;

  logic [CMP_W-1:0] mask;
  logic [CMP_W-1:0] hits;
  logic             forced;
  logic             cond_hit;

  assign mask     = insn[MASK_MSB:MASK_LSB];
  assign hits     = mask_and(cmp, mask);
  assign cond_hit = |hits;
  assign forced   = |force_type;
  assign take     = cond_hit | forced;

  always_comb begin
    // R8
    force_trap_chk: assert (force_type == '0 || take);
    // R9
    quiet_mask_chk: assert (!(mask == '0 && force_type == '0) || !take);
    // R7
    hit_needed_chk: assert (force_type != '0 || take == ((cmp & mask) != '0));
  end
endmodule

// File: rtl/trapcmp_unit.sv
module trapcmp_unit
  import trapcmp_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int HALF     = 32,
  parameter int INSN_W   = 32,
  parameter int MASK_LSB = 21,
  parameter int TYPE_W   = 5
) (
  input  logic [XLEN-1:0]   opa_i,
  input  logic [XLEN-1:0]   opb_i,
  input  logic              narrow_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [TYPE_W-1:0] force_type_i,
  output logic              take_o,
  output logic [CMP_W-1:0]  cmp_o
);
  logic [XLEN-1:0] sa, sb, ua, ub;
  cmp_vec_t        cmp;

  trapcmp_operand_prep #(.XLEN(XLEN), .HALF(HALF)) u_prep (
    .opa(opa_i), .opb(opb_i), .narrow(narrow_i),
    .sa(sa), .sb(sb), .ua(ua), .ub(ub)
  );

  trapcmp_compare #(.XLEN(XLEN)) u_cmp (
    .sa(sa), .sb(sb), .ua(ua), .ub(ub), .cmp(cmp)
  );

  trapcmp_decide #(.INSN_W(INSN_W), .MASK_LSB(MASK_LSB), .TYPE_W(TYPE_W)) u_dec (
    .insn(insn_i), .force_type(force_type_i), .cmp(cmp), .take(take_o)
  );

  assign cmp_o = cmp;

  always_comb begin
    // R6
    half_equal_chk: assert (!(narrow_i && opa_i[HALF-1:0] == opb_i[HALF-1:0]) || cmp_o[EQ_BIT]);
    // R5
    eq_excl_chk: assert (!cmp_o[EQ_BIT] || (!cmp_o[SLT_BIT] && !cmp_o[SGT_BIT] && !cmp_o[ULT_BIT] && !cmp_o[UGT_BIT]));
  end
endmodule

// File: tb/trapcmp_unit_bench.sv
module trapcmp_unit_bench;
  logic        clk = 1'b0;
  logic [63:0] opa, opb;
  logic        narrow;
  logic [31:0] insn;
  logic [4:0]  ftype;
  logic        take;
  logic [4:0]  cmp;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  trapcmp_unit u_trapcmp_unit (
    .opa_i(opa), .opb_i(opb), .narrow_i(narrow), .insn_i(insn),
    .force_type_i(ftype), .take_o(take), .cmp_o(cmp)
  );

  function automatic logic [63:0] rnd(inout logic [63:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 7);
    s = s ^ (s << 17);
    return s;
  endfunction

  // behavioural model: native integer types
  task automatic model(output logic [4:0] ecmp, output logic etake);
    longint          sa, sb;
    longint unsigned ua, ub;
    int unsigned     m;
    if (narrow) begin
      sa = longint'(int'(opa[31:0]));
      sb = longint'(int'(opb[31:0]));
      ua = longint'(opa[31:0]);
      ub = longint'(opb[31:0]);
    end else begin
      sa = opa; sb = opb; ua = opa; ub = opb;
    end
    ecmp[4] = sa < sb;
    ecmp[3] = sa > sb;
    ecmp[2] = ua == ub;
    ecmp[1] = ua < ub;
    ecmp[0] = ua > ub;
    m = (insn >> 21) % 32;
    etake = ((ecmp & m[4:0]) != 0) || (ftype != 0);
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic n,
                       input logic [31:0] i, input logic [4:0] f, input string tag);
    logic [4:0] ecmp;
    logic       etake;
    @(negedge clk);
    opa = a; opb = b; narrow = n; insn = i; ftype = f;
    #2;
    model(ecmp, etake);
    checks++;
    if (cmp !== ecmp || take !== etake) begin
      errors++;
      $display("FAIL %s: cmp=%b take=%b expected cmp=%b take=%b", tag, cmp, take, ecmp, etake);
    end
  endtask

  task automatic expect_cmp(input logic [4:0] want, input string tag);
    checks++;
    if (cmp !== want) begin
      errors++;
      $display("FAIL %s: cmp=%b expected %b", tag, cmp, want);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish expected done=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    opa = '0; opb = '0; narrow = 0; insn = '0; ftype = '0;
    // idle inputs: equal, no trap (R5, R9)
    apply(64'd0, 64'd0, 0, 32'd0, 5'd0, "R9 idle");
    expect_cmp(5'b00100, "R5 idle");
    // -1 vs 1, wide: signed lt, unsigned gt (R4, R5)
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 32'h03E0_0000, 5'd0, "R4 neg vs pos");
    expect_cmp(5'b10001, "R5 neg vs pos");
    // upper halves differ, narrow: equal (R6, R3)
    apply(64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 1, 32'h0080_0000, 5'd0, "R6 half eq");
    expect_cmp(5'b00100, "R3 upper ignored");
    // same, wide: not equal
    apply(64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 0, 32'h0080_0000, 5'd0, "R4 upper counts");
    // bit 31 set, narrow: negative signed (R2)
    apply(64'h0000_0000_8000_0000, 64'd1, 1, 32'h0200_0000, 5'd0, "R2 sign ext");
    expect_cmp(5'b10001, "R2 sign ext vec");
    // same, wide: positive (R4)
    apply(64'h0000_0000_8000_0000, 64'd1, 0, 32'h0200_0000, 5'd0, "R4 positive");
    expect_cmp(5'b01001, "R4 positive vec");
    // each mask bit alone, all other insn bits set (R1, R7)
    for (int k = 0; k < 5; k++) begin
      apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 32'hFC1F_FFFF | (32'd1 << (21 + k)), 5'd0, "R1 mask bit");
      apply(64'd7, 64'd7, 1, 32'hFC1F_FFFF | (32'd1 << (21 + k)), 5'd0, "R7 equal mask");
    end
    // zero mask, garbage elsewhere (R9, R1)
    apply(64'd3, 64'd9, 0, 32'hFC1F_FFFF, 5'd0, "R9 zero mask");
    // forced type with zero mask (R8)
    for (int f = 1; f < 32; f++)
      apply(64'd4, 64'd4, f[0], 32'h0000_0000, f[4:0], "R8 forced");
    // random mix (R10, R7, R2, R3)
    for (int r = 0; r < 4000; r++) begin
      logic [63:0] a, b, w;
      a = rnd(lfsr);
      b = rnd(lfsr);
      w = rnd(lfsr);
      case (w[1:0])
        2'd0: b = a;
        2'd1: b = {b[63:32], a[31:0]};
        default: ;
      endcase
      apply(a, b, w[2], w[63:32], (w[5:3] == 3'd0) ? w[10:6] : 5'd0, "R10 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule